// File: doc/BRIEF.md
# Queue Pointer Interrupt Monitor

This block keeps the head and tail pointers of four interrupt queues that software maintains in memory. The four queues are processor-to-processor messages, device messages, resumable errors and non-resumable errors. Software writes and reads the eight pointers through a simple indexed register port. For each of the first three queues, the block drives an interrupt request to the operating system whenever that queue's head and tail differ, which is the case whenever the queue holds unconsumed entries. The non-resumable error queue stores its pointers but never raises a request.

A request is re-evaluated only when a write lands on its queue's head or tail. Because the pointers change only on such writes, the request always equals the inequality of the stored pointers. Reading memory, wrapping offsets and delivering traps are left to other logic.

Top module: `qmon_top`

## Requirements
- R1: A write with `wr_en_i` high stores all 64 bits of `wr_data_i` into the pointer chosen by `wr_idx_i` at that clock edge, and the pointer holds the value unchanged until the next write to it.
- R2: The index map is fixed. 0/1 are the head/tail of the processor message queue, 2/3 of the device message queue, 4/5 of the resumable error queue and 6/7 of the non-resumable error queue. Bit 0 of the index selects the tail.
- R3: `rd_data_o` is registered. One edge after `rd_idx_i` is applied, it shows the pointer content as it was before that edge, so a read in the same cycle as a write to the same index returns the old value.
- R4: `irq_o[0]`, `irq_o[1]` and `irq_o[2]` belong to the processor message, device message and resumable error queues. Each goes high at the edge of a write that leaves its head different from its tail, including a difference only in bit 63.
- R5: Each of these requests goes low at the edge of a write that leaves its head equal to its tail.
- R6: Writes to the non-resumable error pointers (indices 6 and 7) never change `irq_o`.
- R7: A write to one queue does not change the request of any other queue.
- R8: A synchronous active-high `rst_i` clears all eight pointers, `irq_o` and `rd_data_o` to zero.
- R9: A request changes only at an edge where its own queue is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Pointer write strobe |
| wr_idx_i | input | 3 | Index of the pointer to write (map in R2) |
| wr_data_i | input | 64 | Value to write |
| rd_idx_i | input | 3 | Index of the pointer to read |
| rd_data_o | output | 64 | Registered read data |
| irq_o | output | 3 | Interrupt requests: processor message, device message, resumable error |

## Verification
The hardest cases to reach from the ports are the ones where a request must fall. A queue has to be made unequal, then brought back to equality by a write to the other pointer, and the pointers may differ only in the top bit. The stimulus therefore starts with directed writes of values that differ only in bit 63 and with a same-cycle read and write of one index. It then runs a long random phase that draws pointer values from a pool of four, so that equal and unequal pairs occur often on every queue. A behavioural model in the bench predicts `irq_o` and `rd_data_o` on every clock.

// File: rtl/qmon_pkg.sv
package qmon_pkg;
  parameter int unsigned QMON_NUM_Q   = 4;
  parameter int unsigned QMON_NUM_IRQ = 3;
  parameter int unsigned QMON_PTR_W   = 64;

  typedef enum logic [1:0] {
    Q_CPU_MSG = 2'd0,
    Q_DEV_MSG = 2'd1,
    Q_RES_ERR = 2'd2,
    Q_NRS_ERR = 2'd3
  } qmon_queue_e;
endpackage

// File: rtl/qmon_ptr_pair.sv
module qmon_ptr_pair #(
  parameter int unsigned PTR_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             we_head_i,
  input  logic             we_tail_i,
  input  logic [PTR_W-1:0] wdata_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic [PTR_W-1:0] head_nxt_o,
  output logic [PTR_W-1:0] tail_nxt_o
);
  logic [PTR_W-1:0] head_q, tail_q;

  always_comb begin
    head_nxt_o = we_head_i ? wdata_i : head_q;
    tail_nxt_o = we_tail_i ? wdata_i : tail_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_nxt_o;
      tail_q <= tail_nxt_o;
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;

  AST_HEAD_STORE: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(we_head_i)) |-> (head_q == $past(wdata_i))); // R1
  AST_TAIL_STORE: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(we_tail_i)) |-> (tail_q == $past(wdata_i))); // R1
endmodule

// File: rtl/qmon_req_eval.sv
module qmon_req_eval #(
  parameter int unsigned PTR_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             upd_i,
  input  logic [PTR_W-1:0] head_nxt_i,
  input  logic [PTR_W-1:0] tail_nxt_i,
  output logic             req_o
);
  logic req_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)      req_q <= 1'b0;
    else if (upd_i) req_q <= (head_nxt_i != tail_nxt_i);
  end

  assign req_o = req_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$past(upd_i)) |-> $stable(req_q)); // R9
endmodule

// File: rtl/qmon_rd_mux.sv
module qmon_rd_mux #(
  parameter int unsigned PTR_W = 64,
  parameter int unsigned NUM_Q = 4,
  localparam int unsigned IDX_W = $clog2(2 * NUM_Q)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [PTR_W-1:0] head_i [NUM_Q],
  input  logic [PTR_W-1:0] tail_i [NUM_Q],
  output logic [PTR_W-1:0] rd_data_o
);
  logic [IDX_W-2:0] q_sel;
  logic [PTR_W-1:0] sel_val;
  logic [PTR_W-1:0] rd_q;

  assign q_sel = rd_idx_i[IDX_W-1:1];

  always_comb begin
    sel_val = rd_idx_i[0] ? tail_i[q_sel] : head_i[q_sel];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rd_q <= '0;
    else       rd_q <= sel_val;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/qmon_top.sv
module qmon_top
  import qmon_pkg::*;
#(
  parameter int unsigned PTR_W   = QMON_PTR_W,
  parameter int unsigned NUM_Q   = QMON_NUM_Q,
  parameter int unsigned NUM_IRQ = QMON_NUM_IRQ,
  localparam int unsigned IDX_W  = $clog2(2 * NUM_Q)
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [PTR_W-1:0]   wr_data_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [PTR_W-1:0]   rd_data_o,
  output logic [NUM_IRQ-1:0] irq_o
);
  logic [PTR_W-1:0]   head_w     [NUM_Q];
  logic [PTR_W-1:0]   tail_w     [NUM_Q];
  logic [PTR_W-1:0]   head_nxt_w [NUM_Q];
  logic [PTR_W-1:0]   tail_nxt_w [NUM_Q];
  logic [NUM_Q-1:0]   we_head_w, we_tail_w;
  logic [NUM_IRQ-1:0] req_w;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    assign we_head_w[q] = wr_en_i && (wr_idx_i == IDX_W'(2 * q));
    assign we_tail_w[q] = wr_en_i && (wr_idx_i == IDX_W'(2 * q + 1));

    qmon_ptr_pair #(.PTR_W(PTR_W)) i_pair (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .we_head_i  (we_head_w[q]),
      .we_tail_i  (we_tail_w[q]),
      .wdata_i    (wr_data_i),
      .head_o     (head_w[q]),
      .tail_o     (tail_w[q]),
      .head_nxt_o (head_nxt_w[q]),
      .tail_nxt_o (tail_nxt_w[q])
    );

    if (q < NUM_IRQ) begin : g_req
      qmon_req_eval #(.PTR_W(PTR_W)) i_eval (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .upd_i      (we_head_w[q] | we_tail_w[q]),
        .head_nxt_i (head_nxt_w[q]),
        .tail_nxt_i (tail_nxt_w[q]),
        .req_o      (req_w[q])
      );

      AST_REQ_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
        req_w[q] == (head_w[q] != tail_w[q])); // R4
    end
  end

  qmon_rd_mux #(.PTR_W(PTR_W), .NUM_Q(NUM_Q)) i_rd (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .rd_idx_i  (rd_idx_i),
    .head_i    (head_w),
    .tail_i    (tail_w),
    .rd_data_o (rd_data_o)
  );

  assign irq_o = req_w;

  AST_RST_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |-> (irq_o == '0 && rd_data_o == '0)); // R8
endmodule

// File: tb/test_qmon_top.sv
module test_qmon_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic [2:0]  rd_idx = '0;
  logic [63:0] rd_data;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;

  logic [63:0] m_reg [8];
  logic [2:0]  m_irq = '0;
  logic [63:0] m_rd = '0;

  always #(CLK_P / 2) clk = ~clk;

  qmon_top i_qmon_top (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural reference, evaluated at each rising edge
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) m_reg[i] = '0;
      m_irq = '0;
      m_rd  = '0;
    end else begin
      m_rd = m_reg[rd_idx];
      if (wr_en) begin
        int q;
        m_reg[wr_idx] = wr_data;
        q = wr_idx / 2;
        if (q < 3) m_irq[q] = (m_reg[2*q] != m_reg[2*q+1]);
      end
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #3;
    if (!rst) begin
      chk("R3 readback vs model", rd_data, m_rd);
      chk("R4 R5 R6 R7 R9 irq vs model", {61'd0, irq}, {61'd0, m_irq});
    end
  end

  task automatic wr(input logic [2:0] idx, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx);
    @(negedge clk);
    rd_idx = idx;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] pool [4];
    pool[0] = 64'h0;
    pool[1] = 64'h1;
    pool[2] = 64'h8000_0000_0000_0000;
    pool[3] = 64'hFFFF_FFFF_FFFF_FFFF;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 irq after reset", {61'd0, irq}, 64'd0);
    for (int i = 0; i < 8; i++) begin
      rd(3'(i));
      chk("R8 pointer cleared", rd_data, 64'd0);
    end

    wr(3'd0, 64'h1);
    chk("R4 cpu head differs", {61'd0, irq}, 64'b001);
    wr(3'd1, 64'h1);
    chk("R5 cpu tail equal", {61'd0, irq}, 64'b000);
    wr(3'd3, 64'h8000_0000_0000_0000);
    chk("R2 R4 dev tail bit63 only", {61'd0, irq}, 64'b010);
    wr(3'd4, 64'h55);
    chk("R4 res head differs", {61'd0, irq}, 64'b110);
    wr(3'd6, 64'hAAAA);
    chk("R6 nres head write", {61'd0, irq}, 64'b110);
    wr(3'd7, 64'h1234);
    chk("R6 nres tail write", {61'd0, irq}, 64'b110);
    rd(3'd6);
    chk("R1 R2 nres head readback", rd_data, 64'hAAAA);
    wr(3'd2, 64'h8000_0000_0000_0000);
    chk("R7 dev cleared, res kept", {61'd0, irq}, 64'b100);
    rd(3'd3);
    chk("R1 bit63 readback", rd_data, 64'h8000_0000_0000_0000);

    // same-cycle read and write of index 5
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd5; wr_data = 64'h55; rd_idx = 3'd5;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R3 read during write old value", rd_data, 64'd0);
    chk("R5 res equal", {61'd0, irq}, 64'b000);
    @(negedge clk);
    chk("R3 new value next cycle", rd_data, 64'h55);

    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      wr_en   = ($urandom_range(0, 3) != 0);
      wr_idx  = 3'($urandom_range(0, 7));
      wr_data = pool[$urandom_range(0, 3)];
      rd_idx  = 3'($urandom_range(0, 7));
    end
    @(negedge clk);
    wr_en = 1'b0;

    wr(3'd0, 64'h77);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 mid-run reset irq", {61'd0, irq}, 64'd0);
    rd(3'd0);
    chk("R8 mid-run reset pointer", rd_data, 64'd0);

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule